// File: doc/BRIEF.md
# Ethernet Packet-Handle Queue Manager

This block keeps three first-in first-out queues of 5-bit packet handles for an Ethernet controller whose frame buffers are handed out by an external allocator. The **transmit queue** is filled by the CPU and drained by the transmit engine, one handle per frame it starts. The **completion queue** is filled by the transmit engine as frames leave the wire and drained when the CPU acknowledges a transmit interrupt. The **receive queue** is filled by the receive DMA once a frame has been fully and correctly stored, and drained by the CPU with a plain remove or with a remove that also returns the buffer to the allocator.

The CPU may queue handles for transmit in any order, for example to retry a failed frame or to send back a received frame it has edited. The receive handle is the one granted to the DMA when it first requested memory for the frame. A small capture state machine holds it until the frame ends. It has two states. `CAP_IDLE` waits for a grant, and the transition `T_GRANT` latches the handle and moves to `CAP_HOLD`. `CAP_HOLD` waits for the end of the frame. On a good frame, `T_COMMIT` pushes the held handle into the receive queue and returns to `CAP_IDLE`. On a bad or aborted frame, `T_DROP` returns to `CAP_IDLE` without a push and sends a one-cycle release pulse for the held handle.

A 16-bit port word shows the CPU the heads of the completion and receive queues, each with its own empty bit.

Top module: `pkt_handle_queues`

## Requirements
- R1: While `rst_n` is low all queues are empty. After reset `stat_tx_empty`=1, `stat_tx_int`=0, `tx_head`=5'h1F, `port_reg`=16'h9F9F, `err_flags`=0, and both release valids are 0.
- R2: `cpu_tx_push` appends `cpu_tx_handle` to the transmit queue whatever its value or order. `tx_head` shows the oldest entry. `mac_tx_take` removes it. `stat_tx_empty` is 1 exactly when the transmit queue is empty. All of these become visible one cycle after the edge.
- R3: `mac_tx_done` appends `mac_done_handle` to the completion queue, and `cpu_txc_ack` removes its head. `stat_tx_int` is 1 exactly when that queue is not empty. `port_reg[4:0]` is its head and `port_reg[7]` is 1 when it is empty.
- R4: In `CAP_IDLE`, `dma_alloc_grant` latches `dma_alloc_handle` and enters `CAP_HOLD`. In `CAP_HOLD`, `dma_frame_good` pushes the latched handle into the receive queue in arrival order. `port_reg[12:8]` is the receive head and `port_reg[15]` is 1 when the receive queue is empty.
- R5: In `CAP_HOLD`, `dma_frame_bad` returns to `CAP_IDLE` without a push. In the next cycle `rel_drop_valid` pulses for one cycle with `rel_drop_handle` equal to the latched handle.
- R6: `cpu_rx_remove` and `cpu_rx_remove_release` both pop the receive head. With a non-empty queue, the second also pulses `rel_cpu_valid` for one cycle in the next cycle, with `rel_cpu_handle` equal to the popped handle. If both commands are asserted together, this counts as one remove-and-release.
- R7: A head field whose queue is empty reads as 5'h1F, which is never a valid handle. This applies to `tx_head`, `port_reg[4:0]` and `port_reg[12:8]`. Bits 6:5 and 14:13 of `port_reg` are 0.
- R8: Each queue holds 18 entries. A push to a full queue is dropped and sets a sticky error bit: `err_flags[0]` for transmit, `[1]` for completion and `[2]` for receive. Only reset clears these bits.
- R9: A pop from an empty queue changes nothing in that queue and sets the queue's sticky error bit.
- R10: A push and a pop to the same queue in one cycle are both performed, including when the queue is full. With an empty queue, the pop is flagged as an error and the push is still done.
- R11: In `CAP_HOLD` a further grant is ignored. In `CAP_IDLE`, good and bad have no effect. When good and bad arrive together, bad wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_tx_push | input | 1 | CPU queues a handle for transmit |
| cpu_tx_handle | input | 5 | Handle queued for transmit |
| mac_tx_take | input | 1 | Transmit engine takes the transmit head |
| tx_head | output | 5 | Transmit queue head, 5'h1F when empty |
| stat_tx_empty | output | 1 | Transmit queue empty |
| mac_tx_done | input | 1 | Transmit engine reports a sent frame |
| mac_done_handle | input | 5 | Handle of the sent frame |
| cpu_txc_ack | input | 1 | Transmit interrupt acknowledge, pops completion head |
| stat_tx_int | output | 1 | Completion queue not empty |
| dma_alloc_grant | input | 1 | Allocator granted a receive buffer |
| dma_alloc_handle | input | 5 | Handle of the granted buffer |
| dma_frame_good | input | 1 | Frame stored completely and valid |
| dma_frame_bad | input | 1 | Frame aborted or invalid |
| cpu_rx_remove | input | 1 | Pop receive head |
| cpu_rx_remove_release | input | 1 | Pop receive head and release its buffer |
| port_reg | output | 16 | {rx empty, 00, rx head, done empty, 00, done head} |
| rel_cpu_valid | output | 1 | Release request from a CPU remove-and-release |
| rel_cpu_handle | output | 5 | Handle to release (CPU channel) |
| rel_drop_valid | output | 1 | Release request for a dropped receive frame |
| rel_drop_handle | output | 5 | Handle to release (drop channel) |
| err_flags | output | 3 | Sticky overflow/underflow per queue |

## Verification
The hardest situation to reach is a receive queue holding 18 handles when a good frame ends in the same cycle as a CPU pop. Each receive entry needs a grant followed by a good-frame cycle, so the stimulus first fills the queue with eighteen grant/commit pairs. It then commits a nineteenth frame alone, which must be dropped and flagged, and another together with a remove, which must be accepted. The same full-with-pop corner is driven directly on the transmit and completion queues. A long random phase then mixes all commands, including good and bad together and grants while holding. A behavioural queue model compares every output on every clock.

// File: rtl/phq_pkg.sv
package phq_pkg;
    localparam int HANDLE_W_DEF = 5;
    localparam int QDEPTH_DEF   = 18;
    localparam int NUM_Q        = 3;

    // queue index, also the err_flags bit position
    localparam int Q_TX   = 0;
    localparam int Q_DONE = 1;
    localparam int Q_RX   = 2;

    typedef enum logic {
        CAP_IDLE,
        CAP_HOLD
    } cap_state_e;
endpackage

// File: rtl/phq_fifo.sv
module phq_fifo #(
    parameter int W     = 5,
    parameter int DEPTH = 18
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] push_data,
    input  logic         pop,
    output logic [W-1:0] head,
    output logic         empty,
    output logic         err
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] rd_ptr, wr_ptr;
    logic [CNT_W-1:0] count;
    logic             full, pop_ok, push_ok;

    assign empty   = (count == '0);
    assign full    = (count == FULL_CNT);
    assign pop_ok  = pop && !empty;
    assign push_ok = push && (!full || pop_ok);
    assign head    = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (push_ok) mem[wr_ptr] <= push_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
            err    <= 1'b0;
        end else begin
            if (push_ok) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
            if (pop_ok)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
            unique case ({push_ok, pop_ok})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
            if ((push && !push_ok) || (pop && !pop_ok)) err <= 1'b1;
        end
    end
endmodule

// File: rtl/phq_rx_capture.sv
module phq_rx_capture
    import phq_pkg::*;
#(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         grant,
    input  logic [W-1:0] grant_handle,
    input  logic         good,
    input  logic         bad,
    output logic         commit_push,
    output logic [W-1:0] commit_handle,
    output logic         drop_valid,
    output logic [W-1:0] drop_handle
);
    cap_state_e   state, state_nx;
    logic [W-1:0] held;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= CAP_IDLE;
        else        state <= state_nx;
    end

    // transitions: T_GRANT, T_COMMIT, T_DROP
    always_comb begin
        state_nx = state;
        unique case (state)
            CAP_IDLE: if (grant)        state_nx = CAP_HOLD;
            CAP_HOLD: if (good || bad)  state_nx = CAP_IDLE;
            default:                    state_nx = CAP_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        commit_push   = 1'b0;
        commit_handle = held;
        unique case (state)
            CAP_IDLE: commit_push = 1'b0;
            CAP_HOLD: commit_push = good && !bad;
            default:  commit_push = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            held        <= '0;
            drop_valid  <= 1'b0;
            drop_handle <= '0;
        end else begin
            if (state == CAP_IDLE && grant) held <= grant_handle;
            drop_valid <= (state == CAP_HOLD) && bad;
            if (state == CAP_HOLD && bad) drop_handle <= held;
        end
    end
endmodule

// File: rtl/phq_cpu_port.sv
module phq_cpu_port #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] done_head,
    input  logic         done_empty,
    input  logic [W-1:0] rx_head,
    input  logic         rx_empty,
    input  logic         remove,
    input  logic         remove_release,
    output logic         rx_pop,
    output logic [15:0]  port_word,
    output logic         rel_valid,
    output logic [W-1:0] rel_handle
);
    localparam int PAD = 7 - W;
    localparam logic [W-1:0] NO_HANDLE = '1;

    logic [W-1:0] done_f, rx_f;

    assign done_f    = done_empty ? NO_HANDLE : done_head;
    assign rx_f      = rx_empty   ? NO_HANDLE : rx_head;
    assign port_word = {rx_empty, {PAD{1'b0}}, rx_f, done_empty, {PAD{1'b0}}, done_f};
    assign rx_pop    = remove || remove_release;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rel_valid  <= 1'b0;
            rel_handle <= '0;
        end else begin
            rel_valid <= remove_release && !rx_empty;
            if (remove_release && !rx_empty) rel_handle <= rx_head;
        end
    end
endmodule

// File: rtl/pkt_handle_queues.sv
module pkt_handle_queues
    import phq_pkg::*;
#(
    parameter int HANDLE_W = HANDLE_W_DEF,
    parameter int QDEPTH   = QDEPTH_DEF
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cpu_tx_push,
    input  logic [HANDLE_W-1:0] cpu_tx_handle,
    input  logic                mac_tx_take,
    output logic [HANDLE_W-1:0] tx_head,
    output logic                stat_tx_empty,
    input  logic                mac_tx_done,
    input  logic [HANDLE_W-1:0] mac_done_handle,
    input  logic                cpu_txc_ack,
    output logic                stat_tx_int,
    input  logic                dma_alloc_grant,
    input  logic [HANDLE_W-1:0] dma_alloc_handle,
    input  logic                dma_frame_good,
    input  logic                dma_frame_bad,
    input  logic                cpu_rx_remove,
    input  logic                cpu_rx_remove_release,
    output logic [15:0]         port_reg,
    output logic                rel_cpu_valid,
    output logic [HANDLE_W-1:0] rel_cpu_handle,
    output logic                rel_drop_valid,
    output logic [HANDLE_W-1:0] rel_drop_handle,
    output logic [NUM_Q-1:0]    err_flags
);
    logic [NUM_Q-1:0]    q_push, q_pop, q_empty;
    logic [HANDLE_W-1:0] q_din  [NUM_Q];
    logic [HANDLE_W-1:0] q_head [NUM_Q];

    logic                commit_push;
    logic [HANDLE_W-1:0] commit_handle;
    logic                rx_pop;

    phq_rx_capture #(.W(HANDLE_W)) u_cap (
        .clk          (clk),
        .rst_n        (rst_n),
        .grant        (dma_alloc_grant),
        .grant_handle (dma_alloc_handle),
        .good         (dma_frame_good),
        .bad          (dma_frame_bad),
        .commit_push  (commit_push),
        .commit_handle(commit_handle),
        .drop_valid   (rel_drop_valid),
        .drop_handle  (rel_drop_handle)
    );

    always_comb begin
        q_push[Q_TX]   = cpu_tx_push;
        q_din[Q_TX]    = cpu_tx_handle;
        q_pop[Q_TX]    = mac_tx_take;
        q_push[Q_DONE] = mac_tx_done;
        q_din[Q_DONE]  = mac_done_handle;
        q_pop[Q_DONE]  = cpu_txc_ack;
        q_push[Q_RX]   = commit_push;
        q_din[Q_RX]    = commit_handle;
        q_pop[Q_RX]    = rx_pop;
    end

    for (genvar i = 0; i < NUM_Q; i++) begin : g_q
        phq_fifo #(.W(HANDLE_W), .DEPTH(QDEPTH)) u_fifo (
            .clk      (clk),
            .rst_n    (rst_n),
            .push     (q_push[i]),
            .push_data(q_din[i]),
            .pop      (q_pop[i]),
            .head     (q_head[i]),
            .empty    (q_empty[i]),
            .err      (err_flags[i])
        );
    end

    phq_cpu_port #(.W(HANDLE_W)) u_port (
        .clk           (clk),
        .rst_n         (rst_n),
        .done_head     (q_head[Q_DONE]),
        .done_empty    (q_empty[Q_DONE]),
        .rx_head       (q_head[Q_RX]),
        .rx_empty      (q_empty[Q_RX]),
        .remove        (cpu_rx_remove),
        .remove_release(cpu_rx_remove_release),
        .rx_pop        (rx_pop),
        .port_word     (port_reg),
        .rel_valid     (rel_cpu_valid),
        .rel_handle    (rel_cpu_handle)
    );

    assign tx_head       = q_empty[Q_TX] ? '1 : q_head[Q_TX];
    assign stat_tx_empty = q_empty[Q_TX];
    assign stat_tx_int   = !q_empty[Q_DONE];
endmodule

// File: rtl/phq_checks.sv
module phq_checks (
    input logic        clk,
    input logic        rst_n,
    input logic        cpu_tx_push,
    input logic        mac_tx_done,
    input logic        cpu_txc_ack,
    input logic        cpu_rx_remove,
    input logic        cpu_rx_remove_release,
    input logic        dma_frame_bad,
    input logic        stat_tx_empty,
    input logic        stat_tx_int,
    input logic [15:0] port_reg,
    input logic        rel_cpu_valid,
    input logic        rel_drop_valid,
    input logic [2:0]  err_flags
);
    // R2
    tx_empty_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(stat_tx_empty) |-> $past(cpu_tx_push));
    // R3
    tx_int_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat_tx_int) |-> $past(mac_tx_done));
    // R3
    tx_int_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(stat_tx_int) |-> $past(cpu_txc_ack));
    // R6
    rx_empty_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(port_reg[15]) |-> $past(cpu_rx_remove || cpu_rx_remove_release));
    // R6
    cpu_release_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rel_cpu_valid |-> $past(cpu_rx_remove_release));
    // R5
    drop_release_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rel_drop_valid |-> $past(dma_frame_bad));
    // R8
    sticky_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((err_flags & $past(err_flags)) == $past(err_flags)));
endmodule

bind pkt_handle_queues phq_checks u_checks (
    .clk                  (clk),
    .rst_n                (rst_n),
    .cpu_tx_push          (cpu_tx_push),
    .mac_tx_done          (mac_tx_done),
    .cpu_txc_ack          (cpu_txc_ack),
    .cpu_rx_remove        (cpu_rx_remove),
    .cpu_rx_remove_release(cpu_rx_remove_release),
    .dma_frame_bad        (dma_frame_bad),
    .stat_tx_empty        (stat_tx_empty),
    .stat_tx_int          (stat_tx_int),
    .port_reg             (port_reg),
    .rel_cpu_valid        (rel_cpu_valid),
    .rel_drop_valid       (rel_drop_valid),
    .err_flags            (err_flags)
);

// File: tb/pkt_handle_queues_bench.sv
`timescale 1ns/1ps
module pkt_handle_queues_bench;
    localparam int D = 18;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cpu_tx_push = 0, mac_tx_take = 0, mac_tx_done = 0, cpu_txc_ack = 0;
    logic dma_alloc_grant = 0, dma_frame_good = 0, dma_frame_bad = 0;
    logic cpu_rx_remove = 0, cpu_rx_remove_release = 0;
    logic [4:0] cpu_tx_handle = 0, mac_done_handle = 0, dma_alloc_handle = 0;
    logic [4:0] tx_head, rel_cpu_handle, rel_drop_handle;
    logic stat_tx_empty, stat_tx_int, rel_cpu_valid, rel_drop_valid;
    logic [15:0] port_reg;
    logic [2:0] err_flags;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    pkt_handle_queues u_pkt_handle_queues (
        .clk(clk), .rst_n(rst_n),
        .cpu_tx_push(cpu_tx_push), .cpu_tx_handle(cpu_tx_handle),
        .mac_tx_take(mac_tx_take), .tx_head(tx_head), .stat_tx_empty(stat_tx_empty),
        .mac_tx_done(mac_tx_done), .mac_done_handle(mac_done_handle),
        .cpu_txc_ack(cpu_txc_ack), .stat_tx_int(stat_tx_int),
        .dma_alloc_grant(dma_alloc_grant), .dma_alloc_handle(dma_alloc_handle),
        .dma_frame_good(dma_frame_good), .dma_frame_bad(dma_frame_bad),
        .cpu_rx_remove(cpu_rx_remove), .cpu_rx_remove_release(cpu_rx_remove_release),
        .port_reg(port_reg),
        .rel_cpu_valid(rel_cpu_valid), .rel_cpu_handle(rel_cpu_handle),
        .rel_drop_valid(rel_drop_valid), .rel_drop_handle(rel_drop_handle),
        .err_flags(err_flags)
    );

    // reference model
    logic [4:0] mq [3][$];
    bit         m_hold;
    logic [4:0] m_hh;
    bit         m_rcv, m_rdv;
    logic [4:0] m_rch, m_rdh;
    logic [2:0] m_err;

    task automatic model_reset();
        for (int k = 0; k < 3; k++) mq[k].delete();
        m_hold = 0; m_hh = 0; m_rcv = 0; m_rdv = 0; m_rch = 0; m_rdh = 0; m_err = 0;
    endtask

    task automatic qop(input int k, input bit push, input logic [4:0] d, input bit pop);
        bit pop_ok, push_ok;
        pop_ok  = pop && (mq[k].size() > 0);
        push_ok = push && ((mq[k].size() < D) || pop_ok);
        if (pop_ok) void'(mq[k].pop_front());
        if (push_ok) mq[k].push_back(d);
        if ((push && !push_ok) || (pop && !pop_ok)) m_err[k] = 1'b1;
    endtask

    task automatic model_step();
        bit commit, rxpop, rel;
        rxpop = cpu_rx_remove || cpu_rx_remove_release;
        rel   = cpu_rx_remove_release && (mq[2].size() > 0);
        m_rcv = rel;
        if (rel) m_rch = mq[2][0];
        commit = 0;
        m_rdv  = 0;
        if (!m_hold) begin
            if (dma_alloc_grant) begin m_hold = 1; m_hh = dma_alloc_handle; end
        end else if (dma_frame_bad) begin
            m_rdv = 1; m_rdh = m_hh; m_hold = 0;
        end else if (dma_frame_good) begin
            commit = 1; m_hold = 0;
        end
        qop(0, cpu_tx_push, cpu_tx_handle, mac_tx_take);
        qop(1, mac_tx_done, mac_done_handle, cpu_txc_ack);
        qop(2, commit, m_hh, rxpop);
    endtask

    function automatic logic [4:0] headof(input int k);
        return (mq[k].size() == 0) ? 5'h1F : mq[k][0];
    endfunction

    task automatic check(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic compare();
        logic [15:0] pw;
        string t;
        t = rst_n ? "" : "R1 ";
        pw = {mq[2].size() == 0, 2'b00, headof(2), mq[1].size() == 0, 2'b00, headof(1)};
        check({t, "R2/R7"}, "tx_head", tx_head, headof(0));
        check({t, "R2"}, "stat_tx_empty", stat_tx_empty, mq[0].size() == 0);
        check({t, "R3"}, "stat_tx_int", stat_tx_int, mq[1].size() != 0);
        check({t, "R3/R4/R7"}, "port_reg", port_reg, pw);
        check({t, "R6"}, "rel_cpu_valid", rel_cpu_valid, m_rcv);
        if (m_rcv) check("R6", "rel_cpu_handle", rel_cpu_handle, m_rch);
        check({t, "R5/R11"}, "rel_drop_valid", rel_drop_valid, m_rdv);
        if (m_rdv) check("R5", "rel_drop_handle", rel_drop_handle, m_rdh);
        check({t, "R8/R9/R10"}, "err_flags", err_flags, m_err);
    endtask

    always @(posedge clk) begin
        #1;
        if (!rst_n) model_reset();
        else        model_step();
        compare();
    end

    task automatic clr();
        cpu_tx_push = 0; mac_tx_take = 0; mac_tx_done = 0; cpu_txc_ack = 0;
        dma_alloc_grant = 0; dma_frame_good = 0; dma_frame_bad = 0;
        cpu_rx_remove = 0; cpu_rx_remove_release = 0;
    endtask

    task automatic nxt();
        @(negedge clk);
        clr();
    endtask

    task automatic reset_dut();
        @(negedge clk); clr(); rst_n = 0;
        repeat (2) @(negedge clk);
        rst_n = 1;
    endtask

    task automatic rx_frame(input logic [4:0] h, input bit good);
        dma_alloc_grant = 1; dma_alloc_handle = h; nxt();
        if (good) dma_frame_good = 1; else dma_frame_bad = 1;
        nxt();
    endtask

    initial begin
        reset_dut();                                   // R1 checked in reset cycles
        nxt();
        // R2: out-of-order handles, take order
        cpu_tx_push = 1; cpu_tx_handle = 17; nxt();
        cpu_tx_push = 1; cpu_tx_handle = 3;  nxt();
        cpu_tx_push = 1; cpu_tx_handle = 9;  nxt();
        mac_tx_take = 1; nxt();
        mac_tx_take = 1; nxt();
        mac_tx_take = 1; nxt();
        // R9: take from empty
        mac_tx_take = 1; nxt();
        // R10: push and pop on empty queue
        cpu_tx_push = 1; cpu_tx_handle = 5; mac_tx_take = 1; nxt();
        // R8: fill transmit queue, one overflow, then R10 full push+pop
        reset_dut(); nxt();
        for (int i = 0; i < D; i++) begin cpu_tx_push = 1; cpu_tx_handle = 5'(i); nxt(); end
        cpu_tx_push = 1; cpu_tx_handle = 20; nxt();
        cpu_tx_push = 1; cpu_tx_handle = 21; mac_tx_take = 1; nxt();
        // R3: completion queue and acknowledge, full corner
        for (int i = 0; i < D; i++) begin mac_tx_done = 1; mac_done_handle = 5'(D - 1 - i); nxt(); end
        mac_tx_done = 1; mac_done_handle = 4; cpu_txc_ack = 1; nxt();
        mac_tx_done = 1; mac_done_handle = 6; nxt();
        for (int i = 0; i < D + 1; i++) begin cpu_txc_ack = 1; nxt(); end
        // R4/R5/R6/R11: receive path
        reset_dut(); nxt();
        rx_frame(7, 1);
        rx_frame(12, 0);                               // R5 drop
        rx_frame(2, 1);
        dma_frame_good = 1; nxt();                     // R11 good while idle
        dma_alloc_grant = 1; dma_alloc_handle = 8; nxt();
        dma_alloc_grant = 1; dma_alloc_handle = 9; nxt(); // R11 grant while holding
        dma_frame_good = 1; dma_frame_bad = 1; nxt();  // R11 bad wins
        cpu_rx_remove_release = 1; nxt();              // R6
        cpu_rx_remove = 1; nxt();
        cpu_rx_remove_release = 1; nxt();              // R9 on empty rx
        // R8/R10: fill receive queue via capture
        reset_dut(); nxt();
        for (int i = 0; i < D; i++) rx_frame(5'(i), 1);
        rx_frame(30, 1);                               // overflow, dropped
        dma_alloc_grant = 1; dma_alloc_handle = 25; nxt();
        dma_frame_good = 1; cpu_rx_remove = 1; cpu_rx_remove_release = 1; nxt(); // R10 + R6
        for (int i = 0; i < D + 1; i++) begin cpu_rx_remove = 1; nxt(); end
        // random mix
        reset_dut(); nxt();
        for (int i = 0; i < 3000; i++) begin
            cpu_tx_push = ($urandom % 3) == 0; cpu_tx_handle = 5'($urandom % D);
            mac_tx_take = ($urandom % 4) == 0;
            mac_tx_done = ($urandom % 3) == 0; mac_done_handle = 5'($urandom % D);
            cpu_txc_ack = ($urandom % 4) == 0;
            dma_alloc_grant = ($urandom % 2) == 0; dma_alloc_handle = 5'($urandom % D);
            dma_frame_good = ($urandom % 3) == 0; dma_frame_bad = ($urandom % 7) == 0;
            cpu_rx_remove = ($urandom % 6) == 0; cpu_rx_remove_release = ($urandom % 6) == 0;
            @(negedge clk);
        end
        clr();
        repeat (3) @(negedge clk);
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule